// File: doc/BRIEF.md
# Edge/Center-Aligned PWM Timer Channel

A 16-bit timer counter paired with a single compare channel that produces one PWM output. In edge-aligned mode the counter runs up from zero to a modulo value and then wraps to zero. In center-aligned mode it rises to the modulo value and then falls back to zero, which places the pulse symmetrically around the zero point. A polarity input picks high-true or low-true output.

The modulo and compare values are double-buffered. New values take effect only at the end of a period, so a period or pulse is never cut short by a write. Two sticky flags report period ends (overflow) and compare matches, and each flag has its own one-cycle clear strobe. The mode select is read directly and is meant to change only while the block is held in reset. A synchronous enable freezes the whole channel.

Top module: `pwm_timer_channel`

## Requirements
- R1: In edge-aligned mode (`center_i`=0) the counter goes 0,1,…,M and then back to 0, so the period is M+1 enabled cycles. Every wrap to 0 sets the overflow flag.
- R2: In edge-aligned mode the high-true level is 1 while the counter is below the compare value C. It therefore goes high at the wrap and low at the match. `pwm_o` equals that level XOR `pol_low_i`, so 1 selects low-true output.
- R3: With C=0 the level stays 0 in both modes (0% duty), and the match flag never sets.
- R4: With C>M the level stays 1 (100% duty) and the match flag never sets. With 1≤C≤M the match flag sets in each cycle in which the counter becomes equal to C.
- R5: In center-aligned mode (`center_i`=1, 1≤M≤0x7FFF) the counter goes 0,1,…,M,M-1,…,1,0, so the period is 2M enabled cycles. The overflow flag sets when the counter turns around at 0.
- R6: In center-aligned mode the high-true level clears on a match while rising and sets on a match while falling. The high time per period is 2C for C≤M, and the full period for C≥M.
- R7: `mod_i` and `cmp_i` are sampled only at a period end (wrap or turnaround). The period under way finishes with the old values.
- R8: Each flag stays set until its clear strobe is high at a clock edge. A set event at the same edge overrides the clear.
- R9: While `en_i` is 0 the counter, the output level and the flags do not change. Only the clear strobes act. Counting resumes where it stopped.
- R10: Reset clears the counter and both flags, and drives `pwm_o` to its inactive level (equal to `pol_low_i`). The first enabled cycle after reset is a period end: it loads the settings and sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| center_i | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| pol_low_i | input | 1 | 1 = low-true output |
| mod_i | input | 16 | Modulo (period) value, buffered |
| cmp_i | input | 16 | Compare (duty) value, buffered |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| cmp_clr_i | input | 1 | Match flag clear strobe |
| pwm_o | output | 1 | PWM output |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky match flag |

## Verification
A flag's set event and its clear strobe can land on the same clock edge. During the mode sweeps both clear strobes are held high, so each flag shows exactly the event of the last cycle, and the wrap and match cycles are judged against the arithmetic positions of the counter. A separate run places single clear strobes both on event cycles and on quiet cycles. The flag must survive in the first case and drop in the second.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_OVF  = 0;
  localparam int FLAG_CMP  = 1;
endpackage

// File: rtl/pwm_sticky_flag.sv
module pwm_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic             dn_q_o,
  output logic [CNT_W-1:0] mod_q_o,
  output logic [CNT_W-1:0] cmp_q_o,
  output logic [CNT_W-1:0] cnt_n_o,
  output logic             dn_n_o,
  output logic [CNT_W-1:0] mod_n_o,
  output logic [CNT_W-1:0] cmp_n_o,
  output logic             reload_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, mod_q, cmp_q, cnt_inc;
  logic             dn_q, at_end;

  assign cnt_inc = cnt_q + ONE;

  always_comb begin
    at_end   = center_i ? (dn_q && cnt_q == ZERO) : (cnt_q >= mod_q);
    reload_o = en_i && at_end;
    mod_n_o  = reload_o ? mod_i : mod_q;
    cmp_n_o  = reload_o ? cmp_i : cmp_q;
    cnt_n_o  = cnt_q;
    dn_n_o   = dn_q;
    if (en_i) begin
      if (center_i) begin
        if (dn_q && cnt_q != ZERO) begin
          cnt_n_o = cnt_q - ONE;
        end else begin
          cnt_n_o = cnt_inc;
          dn_n_o  = (cnt_inc >= mod_n_o);  // peak state is tagged falling
        end
      end else begin
        cnt_n_o = at_end ? ZERO : cnt_inc;
        dn_n_o  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b1;
      mod_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_n_o;
      dn_q  <= dn_n_o;
      mod_q <= mod_n_o;
      cmp_q <= cmp_n_o;
    end
  end

  assign cnt_q_o = cnt_q;
  assign dn_q_o  = dn_q;
  assign mod_q_o = mod_q;
  assign cmp_q_o = cmp_q;
endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] cnt_n_i,
  input  logic             dn_n_i,
  input  logic [CNT_W-1:0] mod_n_i,
  input  logic [CNT_W-1:0] cmp_n_i,
  output logic             pwm_raw_o,
  output logic             match_o
);
  logic cmp_nz, lvl_n;

  assign cmp_nz = (cmp_n_i != '0);

  always_comb begin
    if (center_i) lvl_n = cmp_nz && (dn_n_i ? (cnt_n_i <= cmp_n_i) : (cnt_n_i < cmp_n_i));
    else          lvl_n = (cnt_n_i < cmp_n_i);
  end

  // zero and out-of-range compare values never flag
  assign match_o = en_i && cmp_nz && (cmp_n_i <= mod_n_i) && (cnt_n_i == cmp_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_raw_o <= 1'b0;
    else         pwm_raw_o <= lvl_n;
  end
endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             center_i,
  input  logic             pol_low_i,
  input  logic [CNT_W-1:0] mod_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             ovf_clr_i,
  input  logic             cmp_clr_i,
  output logic             pwm_o,
  output logic             ovf_flag_o,
  output logic             cmp_flag_o
);
  logic [CNT_W-1:0] cnt_q, mod_q, cmp_q, cnt_n, mod_n, cmp_n;
  logic             dn_q, dn_n, reload, match_evt, pwm_raw;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

  pwm_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .center_i (center_i),
    .mod_i    (mod_i),
    .cmp_i    (cmp_i),
    .cnt_q_o  (cnt_q),
    .dn_q_o   (dn_q),
    .mod_q_o  (mod_q),
    .cmp_q_o  (cmp_q),
    .cnt_n_o  (cnt_n),
    .dn_n_o   (dn_n),
    .mod_n_o  (mod_n),
    .cmp_n_o  (cmp_n),
    .reload_o (reload)
  );

  pwm_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .center_i  (center_i),
    .cnt_n_i   (cnt_n),
    .dn_n_i    (dn_n),
    .mod_n_i   (mod_n),
    .cmp_n_i   (cmp_n),
    .pwm_raw_o (pwm_raw),
    .match_o   (match_evt)
  );

  assign flag_set[FLAG_OVF] = reload;
  assign flag_set[FLAG_CMP] = match_evt;
  assign flag_clr[FLAG_OVF] = ovf_clr_i;
  assign flag_clr[FLAG_CMP] = cmp_clr_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    pwm_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .flag_o (flag_q[g])
    );
  end

  assign ovf_flag_o = flag_q[FLAG_OVF];
  assign cmp_flag_o = flag_q[FLAG_CMP];
  assign pwm_o      = pwm_raw ^ pol_low_i;
endmodule

// File: rtl/pwm_timer_channel_chk.sv
module pwm_timer_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             center_i,
  input logic             ovf_clr_i,
  input logic             ovf_flag_o,
  input logic             cmp_flag_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] mod_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic             dn_q,
  input logic             reload,
  input logic             pwm_raw
);
  AST_EDGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !center_i && cnt_q >= mod_q |=> cnt_q == '0); // R1

  AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q == '0 |-> !pwm_raw); // R3

  AST_FULL_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q > mod_q && (!center_i || mod_q != '0) |-> pwm_raw); // R4

  AST_MATCH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_flag_o) |-> cmp_q != '0 && cmp_q <= mod_q); // R4

  AST_CTR_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    center_i && !dn_q && mod_q != '0 |-> cnt_q < mod_q); // R5

  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload |=> $stable(mod_q) && $stable(cmp_q)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_flag_o && !ovf_clr_i |=> ovf_flag_o); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i && !reload |=> !ovf_flag_o); // R8

  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q) && $stable(pwm_raw)); // R9
endmodule

bind pwm_timer_channel pwm_timer_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .center_i   (center_i),
  .ovf_clr_i  (ovf_clr_i),
  .ovf_flag_o (ovf_flag_o),
  .cmp_flag_o (cmp_flag_o),
  .cnt_q      (cnt_q),
  .mod_q      (mod_q),
  .cmp_q      (cmp_q),
  .dn_q       (dn_q),
  .reload     (reload),
  .pwm_raw    (pwm_raw)
);

// File: tb/pwm_timer_channel_tb.sv
module pwm_timer_channel_tb;
  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             center_i = 1'b0;
  logic             pol_low_i = 1'b0;
  logic [CNT_W-1:0] mod_i = '0;
  logic [CNT_W-1:0] cmp_i = '0;
  logic             ovf_clr_i = 1'b0;
  logic             cmp_clr_i = 1'b0;
  logic             pwm_o, ovf_flag_o, cmp_flag_o;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_ovf, exp_cmp, exp_pwm;
  int last_lvl;

  pwm_timer_channel #(.CNT_W(CNT_W)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .center_i   (center_i),
    .pol_low_i  (pol_low_i),
    .mod_i      (mod_i),
    .cmp_i      (cmp_i),
    .ovf_clr_i  (ovf_clr_i),
    .cmp_clr_i  (cmp_clr_i),
    .pwm_o      (pwm_o),
    .ovf_flag_o (ovf_flag_o),
    .cmp_flag_o (cmp_flag_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // closed-form counter position after the k-th enabled cycle since a period end
  function automatic void model(input int k, input int m, input int c, input bit ctr,
                                output int lvl, output bit ovf, output bit mt);
    int cnt;
    int q;
    bit dn;
    dn = 1'b0;
    if (!ctr) begin
      q   = (k - 1) % (m + 1);
      cnt = q;
      lvl = (cnt < c) ? 1 : 0;
    end else begin
      q = (k - 1) % (2 * m);
      if (q < m) begin
        cnt = q + 1;
        dn  = (q + 1 >= m);
      end else begin
        cnt = 2 * m - (q + 1);
        dn  = 1'b1;
      end
      lvl = (c != 0 && (dn ? cnt <= c : cnt < c)) ? 1 : 0;
    end
    ovf = (q == 0);
    mt  = (cnt == c) && (c != 0) && (c <= m);
  endfunction

  task automatic reset_to(input bit ctr, input bit pol, input int m, input int c);
    rst_ni = 1'b0; en_i = 1'b0;
    center_i = ctr; pol_low_i = pol;
    mod_i = CNT_W'(m); cmp_i = CNT_W'(c);
    ovf_clr_i = 1'b0; cmp_clr_i = 1'b0;
    @(posedge clk_i); #10;
    chk("R10 pwm idle", int'(pwm_o), int'(pol));
    chk("R10 ovf", int'(ovf_flag_o), 0);
    chk("R10 cmp", int'(cmp_flag_o), 0);
    exp_ovf = 1'b0; exp_cmp = 1'b0; exp_pwm = pol;
    rst_ni = 1'b1; en_i = 1'b1;
  endtask

  task automatic tick(input int k, input int m, input int c, input bit ctr,
                      input bit oclr, input bit cclr,
                      input string rp, input string ro, input string rc);
    int  lvl;
    bit  ov, mt;
    ovf_clr_i = oclr; cmp_clr_i = cclr;
    @(posedge clk_i); #10;
    model(k, m, c, ctr, lvl, ov, mt);
    exp_ovf  = ov ? 1'b1 : (oclr ? 1'b0 : exp_ovf);
    exp_cmp  = mt ? 1'b1 : (cclr ? 1'b0 : exp_cmp);
    exp_pwm  = lvl[0] ^ pol_low_i;
    last_lvl = lvl;
    chk(rp, int'(pwm_o), int'(exp_pwm));
    chk(ro, int'(ovf_flag_o), int'(exp_ovf));
    chk(rc, int'(cmp_flag_o), int'(exp_cmp));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi;
    #20;
    // edge-aligned sweep, clears held high: flag equals last-cycle event
    for (int m = 1; m <= 5; m++)
      for (int c = 0; c <= m + 1; c++)
        for (int p = 0; p < 2; p++) begin
          reset_to(1'b0, p[0], m, c);
          hi = 0;
          for (int k = 1; k <= 2 * (m + 1) + 1; k++) begin
            tick(k, m, c, 1'b0, 1'b1, 1'b1, "R2", "R1", (c == 0) ? "R3" : "R4");
            if (k <= m + 1) hi += last_lvl;
          end
          chk("R2 high count", hi, (c < m + 1) ? c : m + 1);
        end
    // center-aligned sweep
    for (int m = 1; m <= 5; m++)
      for (int c = 0; c <= m + 1; c++)
        for (int p = 0; p < 2; p++) begin
          reset_to(1'b1, p[0], m, c);
          hi = 0;
          for (int k = 1; k <= 4 * m + 1; k++) begin
            tick(k, m, c, 1'b1, 1'b1, 1'b1, "R6", "R5", (c == 0) ? "R3" : "R4");
            if (k <= 2 * m) hi += last_lvl;
          end
          chk("R6 width", hi, (c >= m) ? 2 * m : 2 * c);
        end
    // sticky flags and set-over-clear: wraps at k=1,5,9; matches at k=3,7,11
    reset_to(1'b0, 1'b0, 3, 2);
    for (int k = 1; k <= 12; k++)
      tick(k, 3, 2, 1'b0, (k == 4 || k == 9), (k == 7 || k == 8), "R8", "R8", "R8");
    // enable freeze mid-pulse
    reset_to(1'b0, 1'b0, 4, 2);
    for (int k = 1; k <= 2; k++) tick(k, 4, 2, 1'b0, 1'b0, 1'b0, "R9", "R9", "R9");
    en_i = 1'b0;
    repeat (5) begin
      @(posedge clk_i); #10;
      chk("R9 pwm held", int'(pwm_o), int'(exp_pwm));
      chk("R9 ovf held", int'(ovf_flag_o), int'(exp_ovf));
      chk("R9 cmp held", int'(cmp_flag_o), int'(exp_cmp));
    end
    en_i = 1'b1;
    for (int k = 3; k <= 10; k++) tick(k, 4, 2, 1'b0, 1'b0, 1'b0, "R9", "R9", "R9");
    // buffered settings: change mid-period, old period completes
    reset_to(1'b0, 1'b1, 4, 2);
    for (int k = 1; k <= 3; k++) tick(k, 4, 2, 1'b0, 1'b1, 1'b1, "R7", "R7", "R7");
    mod_i = CNT_W'(6); cmp_i = CNT_W'(5);
    for (int k = 4; k <= 5; k++) tick(k, 4, 2, 1'b0, 1'b1, 1'b1, "R7", "R7", "R7");
    for (int k = 1; k <= 14; k++) tick(k, 6, 5, 1'b0, 1'b1, 1'b1, "R7", "R7", "R7");
    // buffered settings in center mode
    reset_to(1'b1, 1'b0, 3, 1);
    for (int k = 1; k <= 2; k++) tick(k, 3, 1, 1'b1, 1'b1, 1'b1, "R7", "R7", "R7");
    mod_i = CNT_W'(5); cmp_i = CNT_W'(4);
    for (int k = 3; k <= 6; k++) tick(k, 3, 1, 1'b1, 1'b1, 1'b1, "R7", "R7", "R7");
    for (int k = 1; k <= 20; k++) tick(k, 5, 4, 1'b1, 1'b1, 1'b1, "R7", "R7", "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule